// File: doc/BRIEF.md
# External SMI Request Edge Detector

This block turns a falling edge on an asynchronous, active-low request pin into a system management interrupt. The pin is brought into the PCI clock domain through a synchronizer. An edge counts only when the pin was seen high for a minimum run of consecutive samples beforehand, so a slow or bouncing return to high cannot produce a second request. Every accepted edge sets a sticky status flag. When the enable input is also set, the active-low SMI output is pulled low and stays low until software clears the status.

The same pin can also be pulled low by the block itself, as an open-drain output, while an internal serial-IRQ SMI request is active. That self-driven low is masked, so it never appears as an external request.

Top module: `extSmiDetector`

## Requirements
- R1: After reset, `smiStatus` is 0, `smiN` is 1 and `pinDriveLow` is 0.
- R2: A low level on `extPinLevel` that lasts one clock, preceded by at least four high clock samples, sets `smiStatus`. The flag rises on the third rising clock edge after the pin falls, and is 0 after the first and second edges.
- R3: Only the falling transition triggers. A pin held low after the status has been cleared does not set `smiStatus` again.
- R4: An edge is accepted only after the synchronized pin has been high for at least 4 consecutive clock samples. A falling edge after only 3 high samples is ignored, and one after 4 high samples is accepted.
- R5: `smiStatus` is set on an accepted edge whatever the value of `smiEnable`. `smiN` is 0 exactly while both `smiStatus` and `smiEnable` are 1.
- R6: A one-cycle `statusClear` pulse drops `smiStatus` on the next rising edge, and `smiN` then returns to 1.
- R7: `pinDriveLow` is 1 in the same cycle that `sirqSmiReq` is 1, and 0 otherwise. The block never drives the pin high.
- R8: A pin low caused by `pinDriveLow` does not set `smiStatus`. After the self-drive ends, the pin must again be high for 4 samples before an external falling edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rstN | input | 1 | Active-low synchronous reset |
| extPinLevel | input | 1 | Level seen on the request pin (asynchronous, active low) |
| sirqSmiReq | input | 1 | Internal serial-IRQ SMI request |
| smiEnable | input | 1 | Lets the status flag drive the SMI output |
| statusClear | input | 1 | One-cycle pulse that clears the status flag |
| pinDriveLow | output | 1 | Open-drain enable; 1 pulls the request pin low |
| smiN | output | 1 | Active-low system management interrupt |
| smiStatus | output | 1 | Sticky flag set by an accepted edge |

## Verification
The detector is driven with several pin patterns:
- A single-cycle low pulse, sampled at each of the first three edges, pins down the exact latency.
- A long low level with a clear in the middle separates edge triggering from level triggering.
- Back-to-back pulses separated by exactly three and by exactly four high cycles resolve the re-arm threshold to one sample.
- Runs with the enable off and on show that the status flag and the SMI output are distinct.
- A period of self-drive followed by an early and then a late external pulse shows that the block's own open-drain low is masked, and that re-arming restarts after the mask ends.

// File: rtl/extSmiPkg.sv
package extSmiPkg;
  typedef struct packed {
    logic accept;
    logic armed;
  } detStrobe_t;
endpackage

// File: rtl/extSmiSampler.sv
module extSmiSampler
  import extSmiPkg::*;
#(
  parameter int SYNC_DEPTH = 2,
  parameter int HIGH_MIN   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinLevel,
  input  logic       selfDrive,
  output detStrobe_t strobe
);
  localparam int CNT_W = $clog2(HIGH_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HIGH_MIN);

  logic [SYNC_DEPTH-1:0] syncPipe;
  logic [SYNC_DEPTH-1:0] maskPipe;
  logic [CNT_W-1:0]      highCount;
  logic                  sampled;
  logic                  maskAny;

  // synchronizer and an aligned mask pipeline of equal depth
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPipe <= '1;
      maskPipe <= '0;
    end else begin
      syncPipe <= {syncPipe[SYNC_DEPTH-2:0], pinLevel};
      maskPipe <= {maskPipe[SYNC_DEPTH-2:0], selfDrive};
    end
  end

  assign sampled = syncPipe[SYNC_DEPTH-1];
  assign maskAny = selfDrive | (|maskPipe);

  // run length of consecutive high samples, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                       highCount <= '0;
    else if (!sampled || maskAny)    highCount <= '0;
    else if (highCount != CNT_FULL)  highCount <= highCount + 1'b1;
  end

  always_comb begin
    strobe.armed  = (highCount == CNT_FULL);
    strobe.accept = !sampled && strobe.armed && !maskAny;
  end

  // R4: an accepted edge disarms, so two accepts never follow each other
  a_r4_single_accept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |=> !strobe.accept);

  // R8: no acceptance while the block's own drive is active
  a_r8_self_drive_masked: assert property (@(posedge clk) disable iff (!rstN)
    $past(selfDrive) |-> !strobe.accept);
endmodule

// File: rtl/extSmiControl.sv
module extSmiControl
  import extSmiPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  detStrobe_t strobe,
  input  logic       smiEnable,
  input  logic       statusClear,
  output logic       smiStatus,
  output logic       smiN
);
  logic statusQ;

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)              statusQ <= 1'b0;
    else if (strobe.accept) statusQ <= 1'b1;
    else if (statusClear)   statusQ <= 1'b0;
  end

  assign smiStatus = statusQ;
  assign smiN      = !(statusQ && smiEnable);

  // R2: an accepted edge is recorded on the next edge
  a_r2_accept_sets: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |=> smiStatus);

  // R3: the flag is sticky until cleared
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (smiStatus && !statusClear) |=> smiStatus);

  // R6: a clear without a competing event drops the flag
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    (statusClear && !strobe.accept) |=> !smiStatus);

  // R5: the interrupt releases only through a clear or the enable going low
  a_r5_smi_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(smiN) |-> ($past(statusClear) || !smiEnable));
endmodule

// File: rtl/extSmiDetector.sv
module extSmiDetector
  import extSmiPkg::*;
#(
  parameter int SYNC_DEPTH = 2,
  parameter int HIGH_MIN   = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic extPinLevel,
  input  logic sirqSmiReq,
  input  logic smiEnable,
  input  logic statusClear,
  output logic pinDriveLow,
  output logic smiN,
  output logic smiStatus
);
  detStrobe_t strobe;

  // open drain: only ever pulls low
  assign pinDriveLow = sirqSmiReq;

  extSmiSampler #(.SYNC_DEPTH(SYNC_DEPTH), .HIGH_MIN(HIGH_MIN)) sampler (
    .clk       (clk),
    .rstN      (rstN),
    .pinLevel  (extPinLevel),
    .selfDrive (sirqSmiReq),
    .strobe    (strobe)
  );

  extSmiControl control (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .smiEnable   (smiEnable),
    .statusClear (statusClear),
    .smiStatus   (smiStatus),
    .smiN        (smiN)
  );

  // R7: the pad enable tracks the internal request in the same cycle
  a_r7_drive_tracks: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sirqSmiReq) |-> pinDriveLow);
endmodule

// File: tb/extSmiDetector_test.sv
module extSmiDetector_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extDrvN = 1'b1;
  logic sirqSmiReq = 1'b0;
  logic smiEnable = 1'b0;
  logic statusClear = 1'b0;
  logic pinDriveLow, smiN, smiStatus;
  logic pinLevel;
  int checkCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  assign pinLevel = extDrvN & ~pinDriveLow;

  always #(CLK_PERIOD / 2) clk = ~clk;

  extSmiDetector uut (
    .clk         (clk),
    .rstN        (rstN),
    .extPinLevel (pinLevel),
    .sirqSmiReq  (sirqSmiReq),
    .smiEnable   (smiEnable),
    .statusClear (statusClear),
    .pinDriveLow (pinDriveLow),
    .smiN        (smiN),
    .smiStatus   (smiStatus)
  );

  task automatic check(string req, string what, logic act, logic exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearStatus();
    statusClear = 1'b1;
    tick();
    statusClear = 1'b0;
  endtask

  task automatic pulse();
    extDrvN = 1'b0;
    tick();
    extDrvN = 1'b1;
  endtask

  task automatic testReset();
    check("R1", "status after reset", smiStatus, 1'b0);
    check("R1", "smiN after reset", smiN, 1'b1);
    check("R1", "drive after reset", pinDriveLow, 1'b0);
  endtask

  task automatic testLatency();
    tick(8);
    extDrvN = 1'b0;
    tick();
    extDrvN = 1'b1;
    check("R2", "status after edge 1", smiStatus, 1'b0);
    tick();
    check("R2", "status after edge 2", smiStatus, 1'b0);
    tick();
    check("R2", "status after edge 3", smiStatus, 1'b1);
    tick(6);
    clearStatus();
    check("R6", "status after clear", smiStatus, 1'b0);
  endtask

  task automatic testLevel();
    tick(8);
    extDrvN = 1'b0;
    tick(5);
    check("R3", "status on held low", smiStatus, 1'b1);
    clearStatus();
    tick(8);
    check("R3", "held low does not retrigger", smiStatus, 1'b0);
    extDrvN = 1'b1;
    tick(8);
  endtask

  // one pulse, then a second pulse after gap high cycles
  task automatic testRearm(int gap, logic expect2);
    tick(8);
    extDrvN = 1'b0;
    tick();
    extDrvN = 1'b1;
    tick(2);
    check("R4", "first pulse accepted", smiStatus, 1'b1);
    statusClear = 1'b1;
    tick();
    statusClear = 1'b0;
    tick(gap - 3);
    pulse();
    tick(8);
    check("R4", $sformatf("second pulse after %0d high", gap), smiStatus, expect2);
    clearStatus();
  endtask

  task automatic testEnable();
    tick(8);
    smiEnable = 1'b0;
    pulse();
    tick(5);
    check("R5", "status set with enable off", smiStatus, 1'b1);
    check("R5", "smiN high with enable off", smiN, 1'b1);
    smiEnable = 1'b1;
    #1;
    check("R5", "smiN low with enable on", smiN, 1'b0);
    tick();
    clearStatus();
    check("R6", "smiN released after clear", smiN, 1'b1);
    check("R6", "status cleared", smiStatus, 1'b0);
    tick(8);
    pulse();
    tick(5);
    check("R5", "smiN low on new edge", smiN, 1'b0);
    clearStatus();
    smiEnable = 1'b0;
  endtask

  task automatic testSelfDrive();
    tick(8);
    sirqSmiReq = 1'b1;
    #1;
    check("R7", "drive follows request", pinDriveLow, 1'b1);
    check("R7", "pin pulled low", pinLevel, 1'b0);
    tick(5);
    sirqSmiReq = 1'b0;
    #1;
    check("R7", "drive released", pinDriveLow, 1'b0);
    tick(2);
    pulse();
    tick(8);
    check("R8", "self drive and early pulse ignored", smiStatus, 1'b0);
    pulse();
    tick(5);
    check("R8", "pulse after re-arm accepted", smiStatus, 1'b1);
    clearStatus();
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    #1;
    testReset();
    testLatency();
    testLevel();
    testRearm(3, 1'b0);
    testRearm(4, 1'b1);
    testEnable();
    testSelfDrive();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end
endmodule